// File: doc/BRIEF.md
# SPI Command Slave Interface

This block is a mode-0 SPI slave that sits in the system clock domain and turns framed host transactions into accesses on four local resources. It brings SCLK, chip select and MOSI into the system clock domain through synchronizers, assembles bytes MSB first, and treats the first byte of every chip-select frame as an opcode. The opcode decides what the rest of the frame means.

The supported operations are:

- returning a fixed identification byte;
- reading or writing a 32-bit register picked by an index byte;
- streaming bytes into or out of a byte buffer from a start address byte;
- reporting the state of a pair of byte FIFOs;
- popping one byte from the receive FIFO;
- pushing one byte into the transmit FIFO.

Every byte that the slave must return is prepared as soon as the previous byte completes. It is shifted out starting on the falling SCLK edge that closes that previous byte. Any byte that carries no read data comes back as 0xFF.

The register store, the buffer memory and the FIFOs themselves live outside this block.

- The register port and the buffer port use single-cycle strobes. Read data is expected in the cycle after the read strobe.
- The receive FIFO is first-word-fall-through: its head byte is visible whenever it is not empty.

Top module: `cmdspi_slave`

## Requirements
- R1: A frame runs from chip select going low to chip select going high. Bits are sampled on rising SCLK and shifted out on falling SCLK, MSB first. While chip select is high, and during the opcode byte, MISO returns 1s, so the opcode byte reads back as 0xFF. SCLK half periods must be at least SYNC_STAGES+6 clock cycles.
- R2: Opcode 0x00 returns DEVICE_ID in the next byte. Every later byte of the frame returns 0xFF.
- R3: Opcode 0x01 takes an index byte and then issues one reg_rd strobe with reg_idx set to that index. The next four bytes return the 32-bit reg_rdata least significant byte first.
- R4: Opcode 0x02 takes an index byte and then four value bytes, least significant byte first. After the fourth byte it issues exactly one reg_wr strobe carrying that index and value. Bytes after the fourth are ignored.
- R5: Opcode 0x03 takes a start address byte. Each following byte returns the buffer byte at that address, then the next address, and so on. The 8-bit address wraps from 0xFF to 0x00.
- R6: Opcode 0x04 takes a start address byte. Each following byte is written through a buf_we strobe at that address, with the address rising by one per byte and wrapping from 0xFF to 0x00.
- R7: Releasing chip select at any point aborts the frame. The bit count restarts, no strobe is issued, and a register write that has fewer than four value bytes is dropped without a reg_wr.
- R8: Opcode 0x05 returns a status byte. Bit 0 is 1 when the receive FIFO is not empty, bit 1 is 1 when the transmit FIFO is not full, and bits 7..2 are 0.
- R9: Opcode 0x06 returns the receive FIFO head byte and pops it with a single rx_pop. When the FIFO is empty it returns 0x00 and does not pop.
- R10: Opcode 0x07 pushes the next byte through a single tx_push when the transmit FIFO is not full. When the FIFO is full the byte is dropped. Later bytes in the frame are ignored.
- R11: An opcode of 0x08 or above makes every later byte of the frame return 0xFF, and no strobe of any kind is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI clock from host, idle low |
| spi_cs_n | input | 1 | Active-low chip select framing each transaction |
| spi_mosi | input | 1 | Host-to-slave serial data |
| spi_miso | output | 1 | Slave-to-host serial data |
| reg_rd | output | 1 | Register read strobe |
| reg_wr | output | 1 | Register write strobe |
| reg_idx | output | 8 | Register index for either strobe |
| reg_wdata | output | REG_W | Register write value |
| reg_rdata | input | REG_W | Register read value, valid one cycle after reg_rd |
| buf_re | output | 1 | Buffer read strobe |
| buf_we | output | 1 | Buffer write strobe |
| buf_addr | output | ADDR_W | Buffer byte address |
| buf_wdata | output | 8 | Buffer write byte |
| buf_rdata | input | 8 | Buffer read byte, valid one cycle after buf_re |
| rx_empty | input | 1 | Receive FIFO holds no byte |
| rx_data | input | 8 | Receive FIFO head byte |
| rx_pop | output | 1 | Receive FIFO pop strobe |
| tx_full | input | 1 | Transmit FIFO has no room |
| tx_data | output | 8 | Transmit FIFO push byte |
| tx_push | output | 1 | Transmit FIFO push strobe |

## Verification
The bench builds the slave with DEVICE_ID set to 0x5C, not the default, so the identify check cannot pass on a value left in by accident. It keeps REG_W at 32, ADDR_W at 8 and SYNC_STAGES at 2, and drives SCLK with a 10-cycle half period. With an 8-bit address, a stream that starts at 0xFE crosses the wrap to 0x00 within a few bytes. With 32-bit registers, both the least-significant-first byte order and the dropping of a partial write can be seen on a readback. Random register and buffer traffic from a fixed seed is compared against shadow copies that the bench keeps itself.

// File: rtl/cmdspi_pkg.sv
package cmdspi_pkg;

  localparam logic [7:0] OP_IDENT  = 8'h00;
  localparam logic [7:0] OP_RREAD  = 8'h01;
  localparam logic [7:0] OP_RWRITE = 8'h02;
  localparam logic [7:0] OP_BREAD  = 8'h03;
  localparam logic [7:0] OP_BWRITE = 8'h04;
  localparam logic [7:0] OP_QSTAT  = 8'h05;
  localparam logic [7:0] OP_QPOP   = 8'h06;
  localparam logic [7:0] OP_QPUSH  = 8'h07;

  localparam logic [7:0] FILL_BYTE  = 8'hFF;
  localparam logic [7:0] EMPTY_BYTE = 8'h00;

  typedef enum logic [1:0] {PH_CMD, PH_ARG, PH_BODY, PH_DONE} phase_e;

  // FIFO status byte: bit0 receive has data, bit1 transmit has room.
  function automatic logic [7:0] status_byte(input logic rx_empty, input logic tx_full);
    return {6'b000000, ~tx_full, ~rx_empty};
  endfunction

  // Opcodes followed by an index or address byte.
  function automatic logic takes_arg(input logic [7:0] op);
    return (op == OP_RREAD) || (op == OP_RWRITE) || (op == OP_BREAD) || (op == OP_BWRITE);
  endfunction

endpackage

// File: rtl/cmdspi_sync.sv
module cmdspi_sync #(
  parameter int                 WIDTH   = 3,
  parameter int                 STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/cmdspi_shifter.sv
module cmdspi_shifter
  import cmdspi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_s,
  input  logic       cs_n_s,
  input  logic       mosi_s,
  input  logic [7:0] tx_stage,
  output logic       active,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       miso
);

  logic       sclk_d;
  logic       rise, fall;
  logic [2:0] bit_cnt;
  logic [7:0] rx_sh, tx_sh, rx_q;
  logic       done_q;

  assign active = ~cs_n_s;
  assign rise   = active & sclk_s & ~sclk_d;
  assign fall   = active & ~sclk_s & sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= FILL_BYTE;
      rx_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      done_q <= 1'b0;
      if (!active) begin
        bit_cnt <= '0;
        rx_sh   <= '0;
        tx_sh   <= FILL_BYTE;
      end else begin
        if (rise) begin
          rx_sh   <= {rx_sh[6:0], mosi_s};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            done_q <= 1'b1;
            rx_q   <= {rx_sh[6:0], mosi_s};
          end
        end
        if (fall) begin
          if (bit_cnt == 3'd0) tx_sh <= tx_stage;
          else                 tx_sh <= {tx_sh[6:0], 1'b1};
        end
      end
    end
  end

  assign byte_done = done_q;
  assign rx_byte   = rx_q;
  assign miso      = tx_sh[7];

  // Releasing the frame clears the bit position and suppresses completion.
  assert_abort_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (bit_cnt == 3'd0) && !done_q);

  // Output bit only moves on a falling SCLK edge inside a frame.
  assert_miso_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !fall) |=> $stable(tx_sh));

endmodule

// File: rtl/cmdspi_decoder.sv
module cmdspi_decoder
  import cmdspi_pkg::*;
#(
  parameter logic [7:0] DEVICE_ID = 8'hA5,
  parameter int         REG_W     = 32,
  parameter int         ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              byte_done,
  input  logic [7:0]        rx_byte,
  output logic [7:0]        tx_stage,
  output logic              reg_rd,
  output logic              reg_wr,
  output logic [7:0]        reg_idx,
  output logic [REG_W-1:0]  reg_wdata,
  input  logic [REG_W-1:0]  reg_rdata,
  output logic              buf_re,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [7:0]        buf_wdata,
  input  logic [7:0]        buf_rdata,
  input  logic              rx_empty,
  input  logic [7:0]        rx_data,
  output logic              rx_pop,
  input  logic              tx_full,
  output logic [7:0]        tx_data,
  output logic              tx_push
);

  localparam int              REG_NB = REG_W / 8;
  localparam int              CNT_W  = (REG_NB > 1) ? $clog2(REG_NB) : 1;
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(REG_NB - 1);

  // Byte k of a word, least significant first.
  function automatic logic [7:0] byte_of(input logic [REG_W-1:0] w, input logic [CNT_W-1:0] k);
    return 8'(w >> {k, 3'b000});
  endfunction

  // Word with byte k replaced by b.
  function automatic logic [REG_W-1:0] put_byte(input logic [REG_W-1:0] w,
                                                input logic [CNT_W-1:0] k,
                                                input logic [7:0] b);
    logic [REG_W-1:0] m;
    m = {{(REG_W-8){1'b0}}, 8'hFF} << {k, 3'b000};
    return (w & ~m) | ({{(REG_W-8){1'b0}}, b} << {k, 3'b000});
  endfunction

  phase_e           phase;
  logic [7:0]       cmd_q;
  logic [CNT_W-1:0] cnt;
  logic [REG_W-1:0] word_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]       rd_wait;
  logic             any_strobe;

  assign any_strobe = reg_rd | reg_wr | buf_re | buf_we | rx_pop | tx_push;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_CMD;
      cmd_q     <= '0;
      cnt       <= '0;
      word_q    <= '0;
      addr_q    <= '0;
      rd_wait   <= '0;
      tx_stage  <= FILL_BYTE;
      reg_rd    <= 1'b0;
      reg_wr    <= 1'b0;
      reg_idx   <= '0;
      reg_wdata <= '0;
      buf_re    <= 1'b0;
      buf_we    <= 1'b0;
      buf_addr  <= '0;
      buf_wdata <= '0;
      rx_pop    <= 1'b0;
      tx_push   <= 1'b0;
      tx_data   <= '0;
    end else begin
      reg_rd  <= 1'b0;
      reg_wr  <= 1'b0;
      buf_re  <= 1'b0;
      buf_we  <= 1'b0;
      rx_pop  <= 1'b0;
      tx_push <= 1'b0;
      rd_wait <= {rd_wait[0], 1'b0};

      // Read data returns one cycle after the strobe is seen.
      if (rd_wait[1]) begin
        if (cmd_q == OP_RREAD) begin
          word_q   <= reg_rdata;
          tx_stage <= byte_of(reg_rdata, '0);
        end else begin
          tx_stage <= buf_rdata;
        end
      end

      if (!active) begin
        phase    <= PH_CMD;
        cnt      <= '0;
        rd_wait  <= '0;
        tx_stage <= FILL_BYTE;
      end else if (byte_done) begin
        unique case (phase)
          PH_CMD: begin
            cmd_q    <= rx_byte;
            tx_stage <= FILL_BYTE;
            phase    <= takes_arg(rx_byte) ? PH_ARG : PH_DONE;
            case (rx_byte)
              OP_IDENT: tx_stage <= DEVICE_ID;
              OP_QSTAT: tx_stage <= status_byte(rx_empty, tx_full);
              OP_QPOP: begin
                if (!rx_empty) begin
                  tx_stage <= rx_data;
                  rx_pop   <= 1'b1;
                end else begin
                  tx_stage <= EMPTY_BYTE;
                end
              end
              OP_QPUSH: phase <= PH_BODY;
              default: ;
            endcase
          end
          PH_ARG: begin
            cnt   <= '0;
            phase <= PH_BODY;
            case (cmd_q)
              OP_RREAD: begin
                reg_idx <= rx_byte;
                reg_rd  <= 1'b1;
                rd_wait <= 2'b01;
              end
              OP_RWRITE: reg_idx <= rx_byte;
              OP_BREAD: begin
                buf_addr <= rx_byte[ADDR_W-1:0];
                buf_re   <= 1'b1;
                rd_wait  <= 2'b01;
                addr_q   <= rx_byte[ADDR_W-1:0] + 1'b1;
              end
              OP_BWRITE: addr_q <= rx_byte[ADDR_W-1:0];
              default: phase <= PH_DONE;
            endcase
          end
          PH_BODY: begin
            case (cmd_q)
              OP_RREAD: begin
                if (cnt == LAST) begin
                  tx_stage <= FILL_BYTE;
                  phase    <= PH_DONE;
                end else begin
                  tx_stage <= byte_of(word_q, cnt + 1'b1);
                  cnt      <= cnt + 1'b1;
                end
              end
              OP_RWRITE: begin
                word_q <= put_byte(word_q, cnt, rx_byte);
                if (cnt == LAST) begin
                  reg_wr    <= 1'b1;
                  reg_wdata <= put_byte(word_q, cnt, rx_byte);
                  phase     <= PH_DONE;
                end else begin
                  cnt <= cnt + 1'b1;
                end
              end
              OP_BREAD: begin
                buf_addr <= addr_q;
                buf_re   <= 1'b1;
                rd_wait  <= 2'b01;
                addr_q   <= addr_q + 1'b1;
              end
              OP_BWRITE: begin
                buf_addr  <= addr_q;
                buf_wdata <= rx_byte;
                buf_we    <= 1'b1;
                addr_q    <= addr_q + 1'b1;
              end
              OP_QPUSH: begin
                if (!tx_full) begin
                  tx_push <= 1'b1;
                  tx_data <= rx_byte;
                end
                phase <= PH_DONE;
              end
              default: phase <= PH_DONE;
            endcase
          end
          PH_DONE: tx_stage <= FILL_BYTE;
          default: phase <= PH_DONE;
        endcase
      end
    end
  end

  // A pop only follows a cycle in which the receive FIFO had data.
  assert_pop_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> $past(!rx_empty));

  // A push only follows a cycle in which the transmit FIFO had room.
  assert_push_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> $past(!tx_full));

  // A register write is the result of a completed body byte.
  assert_write_on_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> $past(byte_done && active && phase == PH_BODY));

  // Outside a frame no strobe of any kind appears.
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !any_strobe);

  // Once a frame is finished or unknown, it produces no further strobes.
  assert_done_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && phase == PH_DONE) |=> !any_strobe);

endmodule

// File: rtl/cmdspi_slave.sv
module cmdspi_slave
  import cmdspi_pkg::*;
#(
  parameter logic [7:0] DEVICE_ID   = 8'hA5,
  parameter int         REG_W       = 32,
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              reg_rd,
  output logic              reg_wr,
  output logic [7:0]        reg_idx,
  output logic [REG_W-1:0]  reg_wdata,
  input  logic [REG_W-1:0]  reg_rdata,
  output logic              buf_re,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [7:0]        buf_wdata,
  input  logic [7:0]        buf_rdata,
  input  logic              rx_empty,
  input  logic [7:0]        rx_data,
  output logic              rx_pop,
  input  logic              tx_full,
  output logic [7:0]        tx_data,
  output logic              tx_push
);

  logic [2:0] pins_s;
  logic       active, byte_done;
  logic [7:0] rx_byte, tx_stage;

  cmdspi_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({spi_sclk, spi_cs_n, spi_mosi}),
    .q    (pins_s)
  );

  cmdspi_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_s   (pins_s[2]),
    .cs_n_s   (pins_s[1]),
    .mosi_s   (pins_s[0]),
    .tx_stage (tx_stage),
    .active   (active),
    .byte_done(byte_done),
    .rx_byte  (rx_byte),
    .miso     (spi_miso)
  );

  cmdspi_decoder #(
    .DEVICE_ID(DEVICE_ID),
    .REG_W    (REG_W),
    .ADDR_W   (ADDR_W)
  ) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .byte_done(byte_done),
    .rx_byte  (rx_byte),
    .tx_stage (tx_stage),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr),
    .reg_idx  (reg_idx),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .buf_re   (buf_re),
    .buf_we   (buf_we),
    .buf_addr (buf_addr),
    .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata),
    .rx_empty (rx_empty),
    .rx_data  (rx_data),
    .rx_pop   (rx_pop),
    .tx_full  (tx_full),
    .tx_data  (tx_data),
    .tx_push  (tx_push)
  );

  // Register and buffer strobes never overlap.
  assert_single_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_rd, reg_wr, buf_re, buf_we}));

endmodule

// File: tb/cmdspi_slave_bench.sv
module cmdspi_slave_bench;

  localparam logic [7:0] ID  = 8'h5C;
  localparam int         H   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic reg_rd, reg_wr, buf_re, buf_we, rx_pop, tx_push;
  logic [7:0]  reg_idx, buf_addr, buf_wdata, buf_rdata, rx_data, tx_data;
  logic [31:0] reg_wdata, reg_rdata;
  logic rx_empty, tx_full;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cmdspi_slave #(.DEVICE_ID(ID), .REG_W(32), .ADDR_W(8), .SYNC_STAGES(2)) u_cmdspi_slave (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_re(buf_re), .buf_we(buf_we),
    .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .rx_empty(rx_empty), .rx_data(rx_data), .rx_pop(rx_pop), .tx_full(tx_full),
    .tx_data(tx_data), .tx_push(tx_push));

  function automatic logic [31:0] reg_init(input int i);
    return {8'(i), ~8'(i), 8'(i) ^ 8'h55, 8'(i + 1)};
  endfunction
  function automatic logic [7:0] buf_init(input int i);
    return 8'(i) ^ 8'h3C;
  endfunction
  function automatic logic [7:0] lsb_first(input logic [31:0] w, input int k);
    return w[8*k +: 8];
  endfunction

  // Device-side models behind the ports.
  logic [31:0] dev_regs [256];
  logic [7:0]  dev_buf  [256];
  logic [7:0]  rxq [16];
  logic [7:0]  rx_wp = 0, rx_rp;
  logic [7:0]  tx_log [16];
  int n_rd, n_wr, n_bre, n_bwe, n_push, n_all;

  assign rx_empty = (rx_wp == rx_rp);
  assign rx_data  = rxq[rx_rp[3:0]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin
        dev_regs[i] <= reg_init(i);
        dev_buf[i]  <= buf_init(i);
      end
      rx_rp <= 0; n_rd <= 0; n_wr <= 0; n_bre <= 0; n_bwe <= 0; n_push <= 0; n_all <= 0;
      reg_rdata <= 0; buf_rdata <= 0;
    end else begin
      if (reg_rd) begin reg_rdata <= dev_regs[reg_idx]; n_rd <= n_rd + 1; end
      if (reg_wr) begin dev_regs[reg_idx] <= reg_wdata; n_wr <= n_wr + 1; end
      if (buf_re) begin buf_rdata <= dev_buf[buf_addr]; n_bre <= n_bre + 1; end
      if (buf_we) begin dev_buf[buf_addr] <= buf_wdata; n_bwe <= n_bwe + 1; end
      if (rx_pop) rx_rp <= rx_rp + 1;
      if (tx_push) begin tx_log[n_push[3:0]] <= tx_data; n_push <= n_push + 1; end
      if (reg_rd | reg_wr | buf_re | buf_we | rx_pop | tx_push) n_all <= n_all + 1;
    end
  end

  // Bench shadows.
  logic [31:0] exp_regs [256];
  logic [7:0]  exp_buf  [256];
  logic [7:0]  scratch  [8];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] o, output logic [7:0] i);
    for (int b = 7; b >= 0; b--) begin
      mosi = o[b];
      repeat (H) @(negedge clk);
      i[b] = miso;
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic open_tr(input logic [7:0] op);
    logic [7:0] r;
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    xfer(op, r);
    chk("R1 opcode byte reads 0xFF", {24'h0, r}, 32'hFF);
  endtask

  task automatic close_tr;
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * H) @(negedge clk);
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [31:0] v, input int nb);
    logic [7:0] r;
    open_tr(8'h02);
    xfer(idx, r);
    for (int k = 0; k < nb; k++) xfer(lsb_first(v, k), r);
    close_tr();
    if (nb >= 4) exp_regs[idx] = v;
  endtask

  task automatic reg_read(input logic [7:0] idx, output logic [31:0] v);
    logic [7:0] r;
    open_tr(8'h01);
    xfer(idx, r);
    for (int k = 0; k < 4; k++) begin xfer(8'h00, r); v[8*k +: 8] = r; end
    close_tr();
  endtask

  task automatic buf_write(input logic [7:0] a, input int len);
    logic [7:0] r;
    open_tr(8'h04);
    xfer(a, r);
    for (int k = 0; k < len; k++) begin
      xfer(scratch[k], r);
      exp_buf[8'(a + k)] = scratch[k];
    end
    close_tr();
  endtask

  task automatic buf_read_chk(input string tag, input logic [7:0] a, input int len);
    logic [7:0] r;
    open_tr(8'h03);
    xfer(a, r);
    for (int k = 0; k < len; k++) begin
      xfer(8'h00, r);
      chk(tag, {24'h0, r}, {24'h0, exp_buf[8'(a + k)]});
    end
    close_tr();
  endtask

  task automatic one_byte_cmd(input logic [7:0] op, input logic [7:0] arg, output logic [7:0] r);
    open_tr(op);
    xfer(arg, r);
    close_tr();
  endtask

  initial begin
    logic [7:0]  b0, b1;
    logic [31:0] v;
    int base;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) begin exp_regs[i] = reg_init(i); exp_buf[i] = buf_init(i); end
    tx_full = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle MISO high", {31'h0, miso}, 32'h1);

    // R2 identify
    open_tr(8'h00); xfer(8'h00, b0); xfer(8'h00, b1); close_tr();
    chk("R2 identify byte", {24'h0, b0}, {24'h0, ID});
    chk("R2 byte after identify", {24'h0, b1}, 32'hFF);

    // R11 unknown opcode
    base = n_all;
    open_tr(8'h3A); xfer(8'h02, b0); xfer(8'h07, b1); close_tr();
    chk("R11 unknown op byte1", {24'h0, b0}, 32'hFF);
    chk("R11 unknown op byte2", {24'h0, b1}, 32'hFF);
    chk("R11 unknown op no strobe", n_all, base);

    // R4 write, R3 read back
    base = n_wr;
    reg_write(8'h07, 32'hDEADBEEF, 4);
    chk("R4 single reg_wr", n_wr, base + 1);
    chk("R4 stored value", dev_regs[7], 32'hDEADBEEF);
    base = n_rd;
    reg_read(8'h07, v);
    chk("R3 read value LSB first", v, 32'hDEADBEEF);
    chk("R3 single reg_rd", n_rd, base + 1);
    reg_read(8'hC3, v);
    chk("R3 read default value", v, exp_regs[8'hC3]);

    // R7 aborted partial write
    base = n_wr;
    reg_write(8'h07, 32'h11223344, 2);
    chk("R7 partial write no strobe", n_wr, base);
    reg_read(8'h07, v);
    chk("R7 register unchanged", v, exp_regs[7]);
    open_tr(8'h00); xfer(8'h00, b0); close_tr();
    chk("R7 next frame fresh", {24'h0, b0}, {24'h0, ID});

    // R6 / R5 buffer with wrap
    scratch[0] = 8'h91; scratch[1] = 8'h92; scratch[2] = 8'h93; scratch[3] = 8'h94;
    buf_write(8'hFE, 4);
    chk("R6 wrap write at 0x00", {24'h0, dev_buf[0]}, 32'h93);
    chk("R6 write at 0xFF", {24'h0, dev_buf[255]}, 32'h92);
    buf_read_chk("R5 wrap read", 8'hFE, 4);

    // R8 status
    one_byte_cmd(8'h05, 8'h00, b0);
    chk("R8 status empty/room", {24'h0, b0}, 32'h02);
    rxq[0] = 8'hA1; rxq[1] = 8'hB2; rx_wp = 2; tx_full = 1'b1;
    one_byte_cmd(8'h05, 8'h00, b0);
    chk("R8 status data/full", {24'h0, b0}, 32'h01);

    // R10 push while full is dropped
    one_byte_cmd(8'h07, 8'h22, b0);
    chk("R10 full drops push", n_push, 0);
    tx_full = 1'b0;
    open_tr(8'h07); xfer(8'h6E, b0); xfer(8'h11, b1); close_tr();
    chk("R10 one push", n_push, 1);
    chk("R10 pushed byte", {24'h0, tx_log[0]}, 32'h6E);

    // R9 pops
    one_byte_cmd(8'h06, 8'h00, b0);
    chk("R9 pop head", {24'h0, b0}, 32'hA1);
    one_byte_cmd(8'h06, 8'h00, b0);
    chk("R9 pop second", {24'h0, b0}, 32'hB2);
    one_byte_cmd(8'h06, 8'h00, b0);
    chk("R9 empty pop value", {24'h0, b0}, 32'h00);
    chk("R9 empty pop no advance", {24'h0, rx_rp}, 32'h02);

    // Random register and buffer traffic
    for (int t = 0; t < 24; t++) begin
      if ($urandom % 2 == 0) begin
        logic [7:0] idx;
        logic [31:0] val;
        idx = 8'($urandom);
        val = $urandom;
        reg_write(idx, val, 4);
        reg_read(idx, v);
        chk("R4 R3 random register", v, exp_regs[idx]);
      end else begin
        logic [7:0] a;
        int len;
        a = 8'($urandom);
        len = 1 + ($urandom % 6);
        for (int k = 0; k < len; k++) scratch[k] = 8'($urandom);
        buf_write(a, len);
        buf_read_chk("R6 R5 random buffer", a, len);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 180000 && !done) begin
      done = 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog actual=%0d expected=<180000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule